// File: doc/BRIEF.md
# Armed Multi-Source Trigger Qualifier

This block sits in front of a capture controller. It picks one trigger source and emits a single-cycle start pulse when the first qualifying event arrives after the block is armed. Four kinds of source are available:

- a software command;
- an asynchronous digital trigger pin;
- a threshold comparison on one of several sampled analog channels;
- one line of a shared trigger bus.

Edge sensitivity is programmable. Digital and bus sources pass through a synchronizer before edge detection. The analog path compares the upper bits of the selected channel's sample against a level code. It can fire on a crossing or for as long as the comparison holds.

The block is armed by a one-cycle `arm_i` pulse. After the trigger fires, it ignores all further activity until it is armed again. The `triggered_o` flag reports that a trigger has occurred.

Top module: `trig_qualifier`

## Requirements
- R1: After reset, `trig_o` and `triggered_o` are 0 and the block is disarmed; no source can fire until `arm_i` is pulsed.
- R2: A high `arm_i` arms the block and clears `triggered_o` at the next edge. Events seen while disarmed, including edges that occur before arming, never fire.
- R3: Source code 0 (software): `sw_trig_i` sampled high while armed fires `trig_o` in the next cycle.
- R4: Source code 1 (digital pin): `dig_trig_i` passes through a two-flop synchronizer. A qualifying change driven before clock edge k fires `trig_o` after edge k+2.
- R5: Direction code 0 qualifies falling edges only, code 1 rising only, code 2 both, and code 3 none. This applies to the digital, bus and analog-edge paths.
- R6: Source code 3 (bus): only the line indexed by `bus_sel_i` can fire. It has the same synchronizer and latency as R4.
- R7: Source code 2 with `lvl_mode_i`=0 (analog edge): the comparator output is 1 when bits [SAMP_W-1:SAMP_W-LVL_W] of the channel picked by `ana_sel_i` are greater than or equal to `level_i`. Channel c occupies `samp_i[c*SAMP_W +: SAMP_W]`. The comparator is registered, and its edges per R5 fire `trig_o` two cycles after the sample is presented. Level 0xFFF is reached only by the top code.
- R8: Source code 2 with `lvl_mode_i`=1 (analog level): the block fires while armed whenever the registered comparator is 0 (direction code 0) or 1 (any other code). No edge is needed.
- R9: `trig_o` is high for exactly one cycle per firing. `triggered_o` rises with it and stays high until the next `arm_i`.
- R10: After firing, further events on any source have no effect until re-armed.
- R11: If `arm_i` and a qualifying event coincide in one cycle, arming wins: no pulse is emitted, and the block stays armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | Arm pulse; clears the triggered flag |
| sw_trig_i | input | 1 | Software trigger command |
| dig_trig_i | input | 1 | Asynchronous digital trigger pin |
| bus_trig_i | input | NUM_BUS | Asynchronous shared trigger lines |
| samp_i | input | NUM_CH*SAMP_W | Packed per-channel sample words |
| src_sel_i | input | 2 | Source code: 0 software, 1 digital, 2 analog, 3 bus |
| ana_sel_i | input | CH_SEL_W | Analog channel index |
| bus_sel_i | input | BUS_SEL_W | Bus line index |
| level_i | input | LVL_W | Analog threshold code |
| dir_i | input | 2 | Direction: 0 fall, 1 rise, 2 both, 3 none |
| lvl_mode_i | input | 1 | Analog level type (1) instead of edge type (0) |
| trig_o | output | 1 | One-cycle trigger pulse |
| triggered_o | output | 1 | Sticky triggered flag |

## Verification
The digital pin is toggled in both directions under every direction code. This separates the four edge rules and confirms the synchronizer latency. A transition before arming shows that pre-arm edges are rejected. On the bus, a non-selected line is toggled before the selected one, which tells line indexing apart from a plain OR of the lines. Analog stimulus moves a non-selected channel first, and then crosses the level exactly at the threshold code and at the top code 0xFFF, one step either side. Level mode is tried with the comparison already true at arming, which distinguishes it from edge mode. Software commands are repeated after firing and issued together with `arm_i` to expose the ordering between arming and firing.

// File: rtl/trig_qual_pkg.sv
package trig_qual_pkg;

   typedef enum logic [1:0] {
      SRC_SOFT = 2'd0,
      SRC_DIG  = 2'd1,
      SRC_ANA  = 2'd2,
      SRC_BUS  = 2'd3
   } trig_src_e;

   typedef enum logic [1:0] {
      DIR_FALL = 2'd0,
      DIR_RISE = 2'd1,
      DIR_BOTH = 2'd2,
      DIR_NONE = 2'd3
   } edge_dir_e;

   // Qualify a transition of a single bit under the programmed direction
   function automatic logic edge_hit(edge_dir_e dir, logic cur, logic prv);
      logic r;
      case (dir)
         DIR_FALL: r = ~cur & prv;
         DIR_RISE: r = cur & ~prv;
         DIR_BOTH: r = cur ^ prv;
         default:  r = 1'b0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("trig_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("trig_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] stg [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) stg[s] <= '0;
               else        stg[s] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) stg[s] <= '0;
               else        stg[s] <= stg[s-1];
            end
         end
      end
   endgenerate

   assign q_o = stg[STAGES-1];

endmodule

// File: rtl/trig_edge_det.sv
module trig_edge_det
   import trig_qual_pkg::*;
#(
   parameter int WIDTH = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       dir_i,
   input  logic [WIDTH-1:0] cur_i,
   output logic [WIDTH-1:0] hit_o
);

   logic [WIDTH-1:0] prv_q;
   edge_dir_e        dir;

   assign dir = edge_dir_e'(dir_i);

   always_ff @(posedge clk) begin
      if (!rst_n) prv_q <= '0;
      else        prv_q <= cur_i;
   end

   genvar b;
   generate
      for (b = 0; b < WIDTH; b++) begin : g_bit
         assign hit_o[b] = edge_hit(dir, cur_i[b], prv_q[b]);
      end
   endgenerate

endmodule

// File: rtl/trig_ana_cmp.sv
module trig_ana_cmp #(
   parameter int NUM_CH   = 4,
   parameter int SAMP_W   = 14,
   parameter int LVL_W    = 12,
   parameter int CH_SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_CH*SAMP_W-1:0] samp_i,
   input  logic [CH_SEL_W-1:0]      ana_sel_i,
   input  logic [LVL_W-1:0]         level_i,
   output logic                     cmp_o
);

   localparam int PAD_W = SAMP_W - LVL_W;

   generate
      if (LVL_W > SAMP_W) begin : g_bad_lvl
         $error("trig_ana_cmp: LVL_W may not exceed SAMP_W");
      end
   endgenerate

   logic [SAMP_W-1:0] chan [NUM_CH];
   logic [SAMP_W-1:0] sel_samp;
   logic [SAMP_W-1:0] thresh;

   genvar c;
   generate
      for (c = 0; c < NUM_CH; c++) begin : g_chan
         assign chan[c] = samp_i[c*SAMP_W +: SAMP_W];
      end
      if (PAD_W > 0) begin : g_pad
         assign thresh = {level_i, {PAD_W{1'b0}}};
      end else begin : g_nopad
         assign thresh = level_i;
      end
   endgenerate

   always_comb begin
      sel_samp = chan[0];
      for (int i = 0; i < NUM_CH; i++) begin
         if (ana_sel_i == CH_SEL_W'(i)) sel_samp = chan[i];
      end
   end

   // Full-width compare against the padded level equals a compare of the top bits
   always_ff @(posedge clk) begin
      if (!rst_n) cmp_o <= 1'b0;
      else        cmp_o <= (sel_samp >= thresh);
   end

endmodule

// File: rtl/trig_qualifier.sv
module trig_qualifier
   import trig_qual_pkg::*;
#(
   parameter int NUM_CH      = 4,
   parameter int SAMP_W      = 14,
   parameter int LVL_W       = 12,
   parameter int NUM_BUS     = 8,
   parameter int SYNC_STAGES = 2,
   parameter int CH_SEL_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   parameter int BUS_SEL_W   = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     arm_i,
   input  logic                     sw_trig_i,
   input  logic                     dig_trig_i,
   input  logic [NUM_BUS-1:0]       bus_trig_i,
   input  logic [NUM_CH*SAMP_W-1:0] samp_i,
   input  logic [1:0]               src_sel_i,
   input  logic [CH_SEL_W-1:0]      ana_sel_i,
   input  logic [BUS_SEL_W-1:0]     bus_sel_i,
   input  logic [LVL_W-1:0]         level_i,
   input  logic [1:0]               dir_i,
   input  logic                     lvl_mode_i,
   output logic                     trig_o,
   output logic                     triggered_o
);

   generate
      if (NUM_CH < 1 || NUM_BUS < 1) begin : g_bad_count
         $error("trig_qualifier: NUM_CH and NUM_BUS must be positive");
      end
      if (LVL_W < 1 || LVL_W > SAMP_W) begin : g_bad_lvl
         $error("trig_qualifier: LVL_W must lie in 1..SAMP_W");
      end
   endgenerate

   // Digital pin path
   logic dig_s, dig_hit;

   trig_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_dig_sync (
      .clk(clk), .rst_n(rst_n), .d_i(dig_trig_i), .q_o(dig_s));

   trig_edge_det #(.WIDTH(1)) u_dig_edge (
      .clk(clk), .rst_n(rst_n), .dir_i(dir_i), .cur_i(dig_s), .hit_o(dig_hit));

   // Shared bus path
   logic [NUM_BUS-1:0] bus_s, bus_hit;
   logic               bus_ev;

   trig_sync #(.WIDTH(NUM_BUS), .STAGES(SYNC_STAGES)) u_bus_sync (
      .clk(clk), .rst_n(rst_n), .d_i(bus_trig_i), .q_o(bus_s));

   trig_edge_det #(.WIDTH(NUM_BUS)) u_bus_edge (
      .clk(clk), .rst_n(rst_n), .dir_i(dir_i), .cur_i(bus_s), .hit_o(bus_hit));

   always_comb begin
      bus_ev = 1'b0;
      for (int i = 0; i < NUM_BUS; i++) begin
         if (bus_sel_i == BUS_SEL_W'(i)) bus_ev = bus_hit[i];
      end
   end

   // Analog path
   logic ana_cmp, ana_hit, ana_ev;

   trig_ana_cmp #(.NUM_CH(NUM_CH), .SAMP_W(SAMP_W), .LVL_W(LVL_W),
                  .CH_SEL_W(CH_SEL_W)) u_ana_cmp (
      .clk(clk), .rst_n(rst_n), .samp_i(samp_i), .ana_sel_i(ana_sel_i),
      .level_i(level_i), .cmp_o(ana_cmp));

   trig_edge_det #(.WIDTH(1)) u_ana_edge (
      .clk(clk), .rst_n(rst_n), .dir_i(dir_i), .cur_i(ana_cmp), .hit_o(ana_hit));

   always_comb begin
      if (lvl_mode_i) ana_ev = (edge_dir_e'(dir_i) == DIR_FALL) ? ~ana_cmp : ana_cmp;
      else            ana_ev = ana_hit;
   end

   // Source selection
   logic event_sel;

   always_comb begin
      case (trig_src_e'(src_sel_i))
         SRC_SOFT: event_sel = sw_trig_i;
         SRC_DIG:  event_sel = dig_hit;
         SRC_ANA:  event_sel = ana_ev;
         default:  event_sel = bus_ev;
      endcase
   end

   // Arm / fire control
   logic armed_q, trig_q, trd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         trig_q  <= 1'b0;
         trd_q   <= 1'b0;
      end else if (arm_i) begin
         armed_q <= 1'b1;
         trig_q  <= 1'b0;
         trd_q   <= 1'b0;
      end else if (armed_q && event_sel) begin
         armed_q <= 1'b0;
         trig_q  <= 1'b1;
         trd_q   <= 1'b1;
      end else begin
         trig_q  <= 1'b0;
      end
   end

   assign trig_o      = trig_q;
   assign triggered_o = trd_q;

endmodule

// File: rtl/trig_qualifier_chk.sv
module trig_qualifier_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       arm_i,
   input logic       sw_trig_i,
   input logic [1:0] src_sel_i,
   input logic       armed_q,
   input logic       trig_o,
   input logic       triggered_o
);

   assert_pulse_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o |=> !trig_o);

   assert_pulse_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o |-> triggered_o);

   assert_flag_rises_with_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(triggered_o) |-> trig_o);

   assert_single_shot_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (triggered_o && !arm_i) |=> !trig_o);

   assert_arm_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      arm_i |=> (!triggered_o && !trig_o && armed_q));

   assert_soft_fires_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (src_sel_i == 2'd0 && sw_trig_i && armed_q && !arm_i) |=> trig_o);

   assert_disarmed_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed_q && !arm_i) |=> !trig_o);

endmodule

bind trig_qualifier trig_qualifier_chk u_chk (
   .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .sw_trig_i(sw_trig_i),
   .src_sel_i(src_sel_i), .armed_q(armed_q), .trig_o(trig_o),
   .triggered_o(triggered_o));

// File: tb/trig_qualifier_tb_top.sv
module trig_qualifier_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        arm = 1'b0, sw = 1'b0, dig = 1'b0;
   logic [7:0]  bus = '0;
   logic [55:0] samp = '0;
   logic [1:0]  src = 2'd0, dir = 2'd1;
   logic [1:0]  ana_sel = '0;
   logic [2:0]  bus_sel = '0;
   logic [11:0] level = '0;
   logic        lvl_mode = 1'b0;
   logic        trig, trd;

   int checks = 0, fails = 0, cyc = 0;
   string cur_req = "R1";

   always #5 clk = ~clk;

   trig_qualifier dut_i (
      .clk(clk), .rst_n(rst_n), .arm_i(arm), .sw_trig_i(sw), .dig_trig_i(dig),
      .bus_trig_i(bus), .samp_i(samp), .src_sel_i(src), .ana_sel_i(ana_sel),
      .bus_sel_i(bus_sel), .level_i(level), .dir_i(dir), .lvl_mode_i(lvl_mode),
      .trig_o(trig), .triggered_o(trd));

   // Behavioural reference: input histories, not the design's structure
   logic dq[$] = '{1'b0, 1'b0, 1'b0};
   logic [7:0] bq[$] = '{8'h0, 8'h0, 8'h0};
   logic cq[$] = '{1'b0, 1'b0};
   logic m_arm = 0, m_trig = 0, m_trd = 0;

   function automatic logic qual(logic [1:0] d, logic cur, logic prv);
      if (d == 2'd0) return !cur && prv;
      if (d == 2'd1) return cur && !prv;
      if (d == 2'd2) return cur != prv;
      return 1'b0;
   endfunction

   always @(posedge clk) begin
      logic ev;
      logic [13:0] s;
      if (!rst_n) begin
         dq = '{1'b0, 1'b0, 1'b0}; bq = '{8'h0, 8'h0, 8'h0}; cq = '{1'b0, 1'b0};
         m_arm = 0; m_trig = 0; m_trd = 0;
      end else begin
         // dq[0] newest sample, dq[1] synchronized, dq[2] previous synchronized
         case (src)
            2'd0: ev = sw;
            2'd1: ev = qual(dir, dq[1], dq[2]);
            2'd2: ev = lvl_mode ? ((dir == 2'd0) ? !cq[0] : cq[0]) : qual(dir, cq[0], cq[1]);
            default: ev = qual(dir, bq[1][bus_sel], bq[2][bus_sel]);
         endcase
         if (arm) begin m_arm = 1; m_trd = 0; m_trig = 0; end
         else if (m_arm && ev) begin m_arm = 0; m_trd = 1; m_trig = 1; end
         else m_trig = 0;
         dq.push_front(dig); void'(dq.pop_back());
         bq.push_front(bus); void'(bq.pop_back());
         s = samp[ana_sel*14 +: 14];
         cq.push_front((s >> 2) >= level); void'(cq.pop_back());
      end
   end

   task automatic chk(string req, logic act, logic exp, string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%b expected=%b at t=%0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      chk(cur_req, trig, m_trig, "model trig_o");
      chk(cur_req, trd, m_trd, "model triggered_o");
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic arm_pulse();
      arm = 1'b1; step(1); arm = 1'b0;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=<20000 cycles", cyc);
         finish_run();
      end
   end

   initial begin
      // R1 reset state
      step(3);
      chk("R1", trig, 1'b0, "trig_o in reset");
      chk("R1", trd, 1'b0, "triggered_o in reset");
      rst_n = 1'b1; step(2);
      cur_req = "R1"; src = 2'd0; sw = 1'b1; step(2);
      chk("R1", trig, 1'b0, "no fire before first arm"); sw = 1'b0; step(1);

      // R2 pre-arm edge rejected
      cur_req = "R2"; src = 2'd1; dir = 2'd1; dig = 1'b1; step(5);
      chk("R2", trd, 1'b0, "edge while disarmed");
      arm_pulse(); step(4);
      chk("R2", trd, 1'b0, "old edge after arm");
      dig = 1'b0; step(4);

      // R3 software
      cur_req = "R3"; src = 2'd0; arm_pulse();
      sw = 1'b1; step(1);
      chk("R3", trig, 1'b1, "soft fire latency 1");
      sw = 1'b0; step(1);
      chk("R9", trig, 1'b0, "pulse one cycle");
      chk("R9", trd, 1'b1, "flag sticky");
      cur_req = "R10"; sw = 1'b1; step(2);
      chk("R10", trig, 1'b0, "second soft ignored"); sw = 1'b0; step(2);
      chk("R10", trd, 1'b1, "flag still set");

      // R11 arm wins over coincident event
      cur_req = "R11"; arm = 1'b1; sw = 1'b1; step(1);
      chk("R11", trig, 1'b0, "no pulse with arm");
      chk("R11", trd, 1'b0, "flag cleared by arm");
      arm = 1'b0; step(1);
      chk("R11", trig, 1'b1, "still armed after coincidence");
      sw = 1'b0; step(2);

      // R4 / R5 digital under each direction
      src = 2'd1;
      for (int d = 0; d < 4; d++) begin
         cur_req = "R5"; dir = 2'(d); dig = 1'b0; step(4);
         arm_pulse(); dig = 1'b1; step(3);
         chk("R4", trig, (d == 1 || d == 2), "digital rise");
         step(2); arm_pulse(); dig = 1'b0; step(3);
         chk("R5", trig, (d == 0 || d == 2), "digital fall");
         step(2);
      end

      // R6 bus line select
      cur_req = "R6"; src = 2'd3; dir = 2'd1; bus_sel = 3'd5; bus = '0; step(4);
      arm_pulse(); bus[2] = 1'b1; step(5);
      chk("R6", trd, 1'b0, "other bus line ignored");
      bus[5] = 1'b1; step(3);
      chk("R6", trig, 1'b1, "selected bus line fires");
      bus = '0; step(4);

      // R7 analog edge
      cur_req = "R7"; src = 2'd2; lvl_mode = 1'b0; dir = 2'd1; ana_sel = 2'd2;
      level = 12'h800; samp[28 +: 14] = 14'h1FFF; step(3);
      arm_pulse(); samp[14 +: 14] = 14'h3FFF; step(3);
      chk("R7", trd, 1'b0, "other channel ignored");
      samp[28 +: 14] = 14'h2000; step(2);
      chk("R7", trig, 1'b1, "crossing at threshold");
      level = 12'hFFF; samp[28 +: 14] = 14'h3FFB; step(3);
      arm_pulse(); step(3);
      chk("R7", trd, 1'b0, "one below top code");
      samp[28 +: 14] = 14'h3FFC; step(2);
      chk("R7", trig, 1'b1, "top code reaches 0xFFF");
      step(2);

      // R8 analog level mode
      cur_req = "R8"; lvl_mode = 1'b1; dir = 2'd1; level = 12'h400;
      samp[28 +: 14] = 14'h2000; step(3);
      arm_pulse(); step(1);
      chk("R8", trig, 1'b1, "level high fires without edge");
      dir = 2'd0; step(2); arm_pulse(); step(3);
      chk("R8", trd, 1'b0, "fall level not met");
      samp[28 +: 14] = 14'h0100; step(2);
      chk("R8", trig, 1'b1, "fall level met");
      step(3);

      finish_run();
   end

endmodule